// File: doc/BRIEF.md
# Tone Command Receiver

This block accepts tone-selection commands from a host microcontroller and hands each one to a tone synthesizer. It passes on a 5-bit code together with a one-cycle load strobe. The host can send a command in either of two ways. In serial form it clocks five bits in on its own slow clock. In parallel form it places a 4-bit value on a small bus. A mode pin selects which form is in use.

An active-low enable pin gates all operation. While the enable is inactive, the block presents the "tone off" code and accepts nothing. When the enable goes active, the block first waits out a programmable oscillator warm-up interval before it acts on any command. The serial clock and serial data are asynchronous to the system clock. Each passes through a two-stage synchronizer, and the falling edges of the serial clock are found in the system clock domain.

The tone-off code is all ones (5'h1F). Bit 4 of the code separates single tones (1) from dual tones (0).

Top module: `tonecmd_rx`

## Requirements
- R1: In serial mode (`mode_par` = 0), each command is five bits, with the least significant bit sent first. After the fifth bit, `cmd_code` holds the assembled word, `cmd_code[0]` being the first bit received.
- R2: A serial bit is taken at the falling edge of `ser_clk`. A change of `ser_data` while `ser_clk` is low, or at its rising edge, has no effect on the received word.
- R3: A load strobe is issued only after the fifth falling edge. Four falling edges give no strobe, and the bit count restarts from zero after each completed word.
- R4: In parallel mode (`mode_par` = 1), the 4-bit `par_data` is loaded zero-extended, so `cmd_code[4]` = 0. Serial clock edges in parallel mode cause no load and leave `cmd_code` unchanged.
- R5: In parallel mode, a strobe follows when `par_data` takes a value different from the last loaded one and holds it for two consecutive system clocks. A one-cycle glitch produces no strobe.
- R6: After reset, and while `ce_n` is high, `cmd_code` is 5'h1F and `cmd_load` is 0 whatever the other inputs do.
- R7: After `ce_n` falls, no strobe is issued until `STARTUP_CYCLES` system clocks have passed with `ce_n` low. A parallel value already present is then loaded.
- R8: Raising `ce_n` discards a partly received serial word and its bit count. The next five bits after re-enable form a complete new word.
- R9: `cmd_load` lasts exactly one cycle. `cmd_code` changes only together with a strobe or in response to `ce_n` being high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Enable, active low, synchronous to clk |
| mode_par | input | 1 | 1 selects the parallel bus, 0 the serial input |
| ser_clk | input | 1 | Serial bit clock from host, asynchronous, idles high |
| ser_data | input | 1 | Serial data from host, asynchronous |
| par_data | input | PAR_W (4) | Parallel command value, synchronous to clk |
| cmd_code | output | CODE_W (5) | Current command code to the synthesizer |
| cmd_load | output | 1 | One-cycle strobe marking a new command |

## Verification
The assertions assume that `ce_n`, `mode_par` and `par_data` are synchronous to the system clock. They also assume that serial clock phases last several system clocks, so that two loads can never come from adjacent cycles, and that `ser_data` is settled a few clocks before each falling edge of `ser_clk`. The stimulus holds every serial clock phase and data setup for four system clocks or more. It changes the parallel bus and the enable only just after a falling system clock edge. Glitches are applied deliberately as one-cycle pulses.

// File: rtl/tonecmd_pkg.sv
package tonecmd_pkg;

    parameter int CODE_W = 5;
    parameter int PAR_W  = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [PAR_W-1:0]  pbus_t;

    localparam code_t OFF_CODE = '1;

    typedef struct packed {
        logic  valid;
        code_t code;
    } cmd_t;

    function automatic code_t widen(input pbus_t v);
        code_t r;
        r = '0;
        r[PAR_W-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/tonecmd_sync.sv
module tonecmd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tonecmd_warmup.sv
module tonecmd_warmup #(
    parameter int STARTUP_CYCLES = 35800
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    output logic ready
);
    localparam int CW = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ce_n)    cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign ready = !ce_n && (cnt == LIMIT);
endmodule

// File: rtl/tonecmd_serial.sv
module tonecmd_serial
    import tonecmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic fall,
    input  logic bit_in,
    output cmd_t cmd
);
    localparam int NW = $clog2(CODE_W + 1);
    localparam logic [NW-1:0] LAST = NW'(CODE_W - 1);

    code_t         shreg;
    logic [NW-1:0] nbits;
    code_t         next_word;

    assign next_word = {bit_in, shreg[CODE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            shreg <= '0;
            nbits <= '0;
            cmd   <= '0;
        end else begin
            cmd.valid <= 1'b0;
            if (fall) begin
                shreg <= next_word;
                if (nbits == LAST) begin
                    nbits     <= '0;
                    cmd.valid <= 1'b1;
                    cmd.code  <= next_word;
                end else begin
                    nbits <= nbits + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tonecmd_parallel.sv
module tonecmd_parallel
    import tonecmd_pkg::*;
#(
    parameter int STABLE_CYCLES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  pbus_t bus,
    output cmd_t  cmd
);
    localparam int SW = $clog2(STABLE_CYCLES + 1);
    localparam logic [SW-1:0] FIRE_AT = SW'(STABLE_CYCLES - 1);
    localparam logic [SW-1:0] SAT     = SW'(STABLE_CYCLES);

    pbus_t         cand;
    pbus_t         held;
    logic          held_ok;
    logic [SW-1:0] same_cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cand     <= '0;
            held     <= '0;
            held_ok  <= 1'b0;
            same_cnt <= '0;
            cmd      <= '0;
        end else begin
            cmd.valid <= 1'b0;
            if (bus != cand) begin
                cand     <= bus;
                same_cnt <= SW'(1);
            end else begin
                if (same_cnt == FIRE_AT && (!held_ok || held != cand)) begin
                    held      <= cand;
                    held_ok   <= 1'b1;
                    cmd.valid <= 1'b1;
                    cmd.code  <= widen(cand);
                end
                if (same_cnt != SAT) same_cnt <= same_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tonecmd_rx.sv
module tonecmd_rx
    import tonecmd_pkg::*;
#(
    parameter int STARTUP_CYCLES = 35800,
    parameter int STABLE_CYCLES  = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              mode_par,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic [PAR_W-1:0]  par_data,
    output logic [CODE_W-1:0] cmd_code,
    output logic              cmd_load
);
    logic ready;
    logic sclk_s, sdat_s, sclk_d;
    logic fall;
    cmd_t ser_cmd, par_cmd, pick;

    tonecmd_warmup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_warm (
        .clk(clk), .rst(rst), .ce_n(ce_n), .ready(ready)
    );

    tonecmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk (
        .clk(clk), .rst(rst), .d(ser_clk), .q(sclk_s)
    );

    tonecmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdat (
        .clk(clk), .rst(rst), .d(ser_data), .q(sdat_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b1;
        else     sclk_d <= sclk_s;
    end

    assign fall = sclk_d && !sclk_s;

    tonecmd_serial u_ser (
        .clk(clk), .rst(rst), .enable(ready && !mode_par),
        .fall(fall), .bit_in(sdat_s), .cmd(ser_cmd)
    );

    tonecmd_parallel #(.STABLE_CYCLES(STABLE_CYCLES)) u_par (
        .clk(clk), .rst(rst), .enable(ready && mode_par),
        .bus(par_data), .cmd(par_cmd)
    );

    assign pick = mode_par ? par_cmd : ser_cmd;

    always_ff @(posedge clk) begin
        if (rst || ce_n) begin
            cmd_code <= OFF_CODE;
            cmd_load <= 1'b0;
        end else begin
            cmd_load <= pick.valid;
            if (pick.valid) cmd_code <= pick.code;
        end
    end
endmodule

// File: rtl/tonecmd_rx_chk.sv
module tonecmd_rx_chk
    import tonecmd_pkg::*;
#(
    parameter int STARTUP_CYCLES = 35800
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              mode_par,
    input logic [CODE_W-1:0] cmd_code,
    input logic              cmd_load
);
    localparam int LW = $clog2(STARTUP_CYCLES + 2);
    localparam logic [LW-1:0] LSAT = LW'(STARTUP_CYCLES + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || ce_n)        low_cnt <= '0;
        else if (low_cnt != LSAT) low_cnt <= low_cnt + 1'b1;
    end

    // R6
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (cmd_code == OFF_CODE && !cmd_load));

    // R7
    warmup_respected_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_load |-> (low_cnt >= LW'(STARTUP_CYCLES)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_load |=> !cmd_load);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_code) |-> (cmd_load || $past(ce_n)));

    // R4
    par_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && $past(mode_par)) |-> !cmd_code[CODE_W-1]);
endmodule

bind tonecmd_rx tonecmd_rx_chk #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .mode_par(mode_par),
    .cmd_code(cmd_code), .cmd_load(cmd_load)
);

// File: tb/tonecmd_rx_test.sv
module tonecmd_rx_test;
    localparam int CLK_P   = 10;
    localparam int WARM    = 40;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1;
    logic       mode_par = 1'b0;
    logic       ser_clk = 1'b1;
    logic       ser_data = 1'b0;
    logic [3:0] par_data = 4'h0;
    logic [4:0] cmd_code;
    logic       cmd_load;

    int checks = 0;
    int errors = 0;
    int loads = 0;
    logic [4:0] last_code;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tonecmd_rx #(.STARTUP_CYCLES(WARM)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .mode_par(mode_par),
        .ser_clk(ser_clk), .ser_data(ser_data), .par_data(par_data),
        .cmd_code(cmd_code), .cmd_load(cmd_load)
    );

    always @(negedge clk) begin
        if (cmd_load) begin
            loads++;
            last_code = cmd_code;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enable_and_warm();
        ce_n = 1'b0;
        tick(WARM + 6);
    endtask

    task automatic send_bits(input logic [4:0] v, input int n, input bit wiggle);
        for (int i = 0; i < n; i++) begin
            ser_data = v[i];
            tick(4);
            ser_clk = 1'b0;
            tick(5);
            if (wiggle) ser_data = ~v[i];
            tick(4);
            ser_clk = 1'b1;
            tick(4);
        end
        tick(6);
    endtask

    task automatic t_reset();
        check(cmd_code == 5'h1F, "R6 reset code", cmd_code, 5'h1F);
        check(cmd_load == 1'b0, "R6 reset load", cmd_load, 0);
    endtask

    task automatic t_serial_words();
        logic [4:0] pats [4] = '{5'b10110, 5'b00001, 5'b01101, 5'b10000};
        mode_par = 1'b0;
        enable_and_warm();
        foreach (pats[k]) begin
            loads = 0;
            send_bits(pats[k], 5, 1'b0);
            check(loads == 1, "R1 one load per word", loads, 1);
            check(cmd_code == pats[k], "R1 word LSB first", cmd_code, pats[k]);
        end
    endtask

    task automatic t_falling_capture();
        loads = 0;
        send_bits(5'b01011, 5, 1'b1);
        check(loads == 1 && last_code == 5'b01011, "R2 falling-edge capture", last_code, 5'b01011);
    endtask

    task automatic t_count();
        loads = 0;
        send_bits(5'b00111, 4, 1'b0);
        check(loads == 0, "R3 four edges no load", loads, 0);
        check(cmd_code == 5'b01011, "R3 code held", cmd_code, 5'b01011);
        send_bits(5'b11111, 1, 1'b0);
        check(loads == 1 && cmd_code == 5'b10111, "R3 fifth edge completes", cmd_code, 5'b10111);
        loads = 0;
        send_bits(5'b00010, 5, 1'b0);
        check(cmd_code == 5'b00010 && loads == 1, "R3 count restarts", cmd_code, 5'b00010);
    endtask

    task automatic t_abort();
        loads = 0;
        send_bits(5'b00111, 3, 1'b0);
        ce_n = 1'b1;
        tick(3);
        check(cmd_code == 5'h1F, "R6 off while disabled", cmd_code, 5'h1F);
        par_data = 4'h6;
        send_bits(5'b01010, 5, 1'b0);
        check(loads == 0 && cmd_code == 5'h1F, "R6 inputs ignored", cmd_code, 5'h1F);
        enable_and_warm();
        send_bits(5'b11000, 5, 1'b0);
        check(loads == 1 && cmd_code == 5'b11000, "R8 partial word dropped", cmd_code, 5'b11000);
    endtask

    task automatic t_warmup();
        int early = 0;
        ce_n = 1'b1;
        mode_par = 1'b1;
        par_data = 4'h9;
        tick(3);
        loads = 0;
        ce_n = 1'b0;
        tick(WARM);
        early = loads;
        check(early == 0, "R7 no load during warm-up", early, 0);
        tick(8);
        check(loads == 1 && cmd_code == 5'h09, "R7 load after warm-up", cmd_code, 5'h09);
    endtask

    task automatic t_parallel();
        loads = 0;
        par_data = 4'hC;
        tick(6);
        check(loads == 1 && cmd_code == 5'h0C, "R4 zero-extended load", cmd_code, 5'h0C);
        loads = 0;
        par_data = 4'h3;
        tick(1);
        par_data = 4'hC;
        tick(6);
        check(loads == 0 && cmd_code == 5'h0C, "R5 glitch ignored", cmd_code, 5'h0C);
        par_data = 4'h5;
        tick(1);
        par_data = 4'hA;
        tick(6);
        check(loads == 1 && cmd_code == 5'h0A, "R5 settled value loaded", cmd_code, 5'h0A);
        loads = 0;
        tick(10);
        check(loads == 0, "R5 no repeat on steady bus", loads, 0);
        send_bits(5'b10101, 5, 1'b0);
        check(loads == 0 && cmd_code == 5'h0A, "R4 serial ignored in parallel mode", cmd_code, 5'h0A);
        par_data = 4'hF;
        tick(6);
        check(loads == 1 && cmd_code == 5'h0F && !cmd_code[4], "R4 max value", cmd_code, 5'h0F);
    endtask

    task automatic t_pulse();
        int ones = 0;
        par_data = 4'h1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cmd_load) ones++;
        end
        check(ones == 1, "R9 strobe one cycle", ones, 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst = 1'b0;
        tick(2);
        t_reset();
        t_serial_words();
        t_falling_capture();
        t_count();
        t_abort();
        t_warmup();
        t_parallel();
        t_pulse();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule